// File: doc/BRIEF.md
# Dual-Channel Link Transmitter with Shared Backpressure

This block takes a stream of 32-bit words from a front-end source, holds them in a small FIFO and sends the same word sequence out on two serial-link lanes at once. Each lane hands its serializer a 16-bit half-word per clock, so every word takes two lane cycles: the low half first, then the high half. When no word is being sent, each lane carries an idle control word, which the lane's control flag marks.

Each downstream receiver has its own stop (XOFF) input. Each stop is resynchronised through two flops, and the two results are ORed together. While the combined stop is active, no new word leaves the FIFO. The FIFO then fills, and the source sees `in_ready` drop. A stall takes effect only between words, so a half-word is never left stranded on a lane. The source and link sides share one clock edge. The slower source rate shows up as gaps in `in_valid`.

The source interface is valid/ready. A word transfers on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` is low exactly when the FIFO holds `DEPTH` words. The source may hold `in_valid` high with stable data for as long as `in_ready` is low; nothing is taken while `in_ready` is low. The stop inputs may change at any time.

Top module: `duo_link_tx`

## Requirements
- R1: After reset, `in_ready` is 1 and both lanes output the idle word: control flag 1, data equal to `IDLE_WORD` (default 16'h50BC).
- R2: Each accepted word appears on a lane as two consecutive cycles with control flag 0: bits [15:0] in the first cycle, then bits [31:16] in the next.
- R3: In every cycle, lane A and lane B carry the same data and the same control flag.
- R4: Words leave in the order they were accepted. `in_ready` is 0 exactly when `DEPTH` words are held, and no word is taken in a cycle where `in_ready` is 0.
- R5: A stop on lane A's input alone halts transmission. Once it has been held for four clock cycles, no new word starts.
- R6: A stop on lane B's input alone halts transmission in the same way as R5.
- R7: A word is never split. A first half is always followed in the very next cycle by its second half, even if a stop arrives in between.
- R8: Once all stops are released, transmission resumes. Across any number of stall and release cycles, no word is lost or duplicated.
- R9: When no word is held, or a stop is active at a word boundary, the lanes output the idle word with control flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared source and link clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Word from the source |
| in_valid | input | 1 | Source has a word on `in_data` |
| in_ready | output | 1 | FIFO can take a word |
| xoff_a | input | 1 | Stop request from lane A's receiver, asynchronous |
| xoff_b | input | 1 | Stop request from lane B's receiver, asynchronous |
| lane_a_data | output | 16 | Half-word or idle word to lane A's serializer |
| lane_a_ctrl | output | 1 | 1 when lane A carries the idle word |
| lane_b_data | output | 16 | Half-word or idle word to lane B's serializer |
| lane_b_ctrl | output | 1 | 1 when lane B carries the idle word |

## Verification
A wrong FIFO count or pointer shows at the ports as a dropped, repeated or reordered word. It is caught within two cycles of that word reaching the lanes, by comparing each reassembled word against the word the source handed in. A stuck half-word phase shows as a control flag that rises between two halves, or as halves in the wrong order, on the very next cycle. A broken stop path shows as data still flowing more than four cycles after a stop is raised, or as `in_ready` staying high when the FIFO should be full.

// File: rtl/duo_link_pkg.sv
package duo_link_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef struct packed {
    logic              ctrl;
    logic [HALF_W-1:0] data;
  } lane_t;
endpackage

// File: rtl/duo_stop_sync.sv
module duo_stop_sync #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] stop_raw,
  output logic [LANES-1:0] stop_synced
);
  logic [LANES-1:0] stage1;
  logic [LANES-1:0] stage2;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          stage1[g] <= 1'b0;
          stage2[g] <= 1'b0;
        end else begin
          stage1[g] <= stop_raw[g];
          stage2[g] <= stage1[g];
        end
      end
    end
  endgenerate

  assign stop_synced = stage2;
endmodule

// File: rtl/duo_word_fifo.sv
module duo_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  input  logic             rd_en
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_COUNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_wr, do_rd;

  assign wr_ready = (count != FULL_COUNT);
  assign rd_valid = (count != '0);
  assign do_wr    = wr_valid && wr_ready;
  assign do_rd    = rd_en && rd_valid;
  assign rd_data  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4: occupancy never exceeds the configured depth
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_COUNT);

  // R4: a write refused while full leaves the count unchanged unless a read happens
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready && !rd_en) |=> (count == FULL_COUNT));
endmodule

// File: rtl/duo_half_splitter.sv
module duo_half_splitter
  import duo_link_pkg::*;
#(
  parameter logic [HALF_W-1:0] IDLE_WORD = 16'h50BC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  logic              word_valid,
  output logic              word_take,
  input  logic              stop,
  output lane_t             lane_out
);
  logic              high_due;
  logic [HALF_W-1:0] high_hold;

  // a new word starts only on a boundary with no stop active
  assign word_take = !high_due && word_valid && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      high_due      <= 1'b0;
      high_hold     <= '0;
      lane_out.ctrl <= 1'b1;
      lane_out.data <= IDLE_WORD;
    end else if (high_due) begin
      high_due      <= 1'b0;
      lane_out.ctrl <= 1'b0;
      lane_out.data <= high_hold;
    end else if (word_take) begin
      high_due      <= 1'b1;
      high_hold     <= word[WORD_W-1:HALF_W];
      lane_out.ctrl <= 1'b0;
      lane_out.data <= word[HALF_W-1:0];
    end else begin
      lane_out.ctrl <= 1'b1;
      lane_out.data <= IDLE_WORD;
    end
  end

  // R7: once a first half is out, the second half follows with no idle between
  assert_word_whole_R7: assert property (@(posedge clk) disable iff (rst)
    high_due |=> (lane_out.ctrl == 1'b0));

  // R5: a stop seen at a word boundary yields an idle cycle
  assert_stall_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    (!high_due && stop) |=> (lane_out.ctrl == 1'b1 && lane_out.data == IDLE_WORD));

  // R9: nothing to send at a boundary gives the idle word
  assert_idle_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (!high_due && !word_valid) |=> (lane_out.ctrl == 1'b1 && lane_out.data == IDLE_WORD));
endmodule

// File: rtl/duo_link_tx.sv
module duo_link_tx
  import duo_link_pkg::*;
#(
  parameter int                DEPTH     = 8,
  parameter logic [HALF_W-1:0] IDLE_WORD = 16'h50BC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              xoff_a,
  input  logic              xoff_b,
  output logic [HALF_W-1:0] lane_a_data,
  output logic              lane_a_ctrl,
  output logic [HALF_W-1:0] lane_b_data,
  output logic              lane_b_ctrl
);
  localparam int LANES = 2;

  logic [LANES-1:0]  stop_synced;
  logic              stop_any;
  logic [WORD_W-1:0] head_word;
  logic              head_valid;
  logic              head_take;
  lane_t             lane_word;
  lane_t             lane_out [LANES];

  duo_stop_sync #(.LANES(LANES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .stop_raw    ({xoff_b, xoff_a}),
    .stop_synced (stop_synced)
  );

  assign stop_any = |stop_synced;

  duo_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (in_data),
    .wr_valid (in_valid),
    .wr_ready (in_ready),
    .rd_data  (head_word),
    .rd_valid (head_valid),
    .rd_en    (head_take)
  );

  duo_half_splitter #(.IDLE_WORD(IDLE_WORD)) u_split (
    .clk        (clk),
    .rst        (rst),
    .word       (head_word),
    .word_valid (head_valid),
    .word_take  (head_take),
    .stop       (stop_any),
    .lane_out   (lane_word)
  );

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_fan
      assign lane_out[g] = lane_word;
    end
  endgenerate

  assign lane_a_data = lane_out[0].data;
  assign lane_a_ctrl = lane_out[0].ctrl;
  assign lane_b_data = lane_out[1].data;
  assign lane_b_ctrl = lane_out[1].ctrl;

  // R5/R6: a synchronised stop from either lane forbids starting a word
  assert_either_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (stop_synced != '0) |-> !head_take);
endmodule

// File: tb/duo_link_tx_test.sv
module duo_link_tx_test;
  localparam int DEPTH = 8;
  localparam logic [15:0] IDLE = 16'h50BC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        xoff_a = 1'b0, xoff_b = 1'b0;
  logic [15:0] lane_a_data, lane_b_data;
  logic        lane_a_ctrl, lane_b_ctrl;

  int checks = 0;
  int errors = 0;
  logic [31:0] expq [$];
  int  got_words = 0;
  logic        want_high = 1'b0;
  logic [15:0] low_half = '0;
  logic        mon_on = 1'b0;

  duo_link_tx #(.DEPTH(DEPTH), .IDLE_WORD(IDLE)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .xoff_a(xoff_a), .xoff_b(xoff_b),
    .lane_a_data(lane_a_data), .lane_a_ctrl(lane_a_ctrl),
    .lane_b_data(lane_b_data), .lane_b_ctrl(lane_b_ctrl)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: lane equality, half ordering, word reassembly against the source order
  always @(negedge clk) begin
    if (mon_on) begin
      if (lane_a_data !== lane_b_data || lane_a_ctrl !== lane_b_ctrl)
        check(0, "R3 lanes differ", {lane_a_ctrl, 15'd0, lane_a_data}, {lane_b_ctrl, 15'd0, lane_b_data});
      if (want_high) begin
        check(lane_a_ctrl == 1'b0, "R7 second half missing", {31'd0, lane_a_ctrl}, 32'd0);
        if (lane_a_ctrl == 1'b0) begin
          if (expq.size() == 0)
            check(0, "R8 unexpected extra word", {lane_a_data, low_half}, 32'd0);
          else
            check({lane_a_data, low_half} == expq[0], "R2/R4 word order",
                  {lane_a_data, low_half}, expq[0]);
          if (expq.size() != 0) void'(expq.pop_front());
          got_words++;
        end
        want_high = 1'b0;
      end else if (lane_a_ctrl == 1'b0) begin
        low_half  = lane_a_data;
        want_high = 1'b1;
      end else if (lane_a_data !== IDLE) begin
        check(0, "R9 idle word value", {16'd0, lane_a_data}, {16'd0, IDLE});
      end
    end
  end

  task automatic push(input logic [31:0] w);
    bit r;
    in_data  = w;
    in_valid = 1'b1;
    expq.push_back(w);
    do begin
      r = in_ready;
      @(negedge clk);
    end while (!r);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((expq.size() != 0 || want_high) && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
    check(lane_a_ctrl == 1'b1 && lane_b_ctrl == 1'b1, "R1 ctrl after reset",
          {30'd0, lane_a_ctrl, lane_b_ctrl}, 32'd3);
    check(lane_a_data == IDLE && lane_b_data == IDLE, "R1 idle data after reset",
          {lane_a_data, lane_b_data}, {IDLE, IDLE});
    mon_on = 1'b1;
  endtask

  task automatic test_stream;
    push(32'h1234_ABCD);
    push(32'hFFFF_0000);
    push(32'h0000_FFFF);
    for (int i = 0; i < 10; i++) push(32'hA5A5_0000 + 32'(i * 7));
    drain("R2 stream delivered");
    repeat (3) @(negedge clk);
    check(lane_a_ctrl == 1'b1 && lane_a_data == IDLE, "R9 idle when empty",
          {lane_a_ctrl, 15'd0, lane_a_data}, {1'b1, 15'd0, IDLE});
  endtask

  task automatic test_stop(input bit use_a, input string req);
    int started;
    for (int i = 0; i < 4; i++) push(32'hC0DE_0000 + 32'(i));
    if (use_a) xoff_a = 1'b1; else xoff_b = 1'b1;
    repeat (4) @(negedge clk);
    started = got_words;
    for (int i = 0; i < 12; i++) begin
      check(lane_a_ctrl == 1'b1, req, {31'd0, lane_a_ctrl}, 32'd1);
      @(negedge clk);
    end
    check(got_words == started, req, got_words, started);
    xoff_a = 1'b0;
    xoff_b = 1'b0;
    drain("R8 resume after stop");
  endtask

  task automatic test_fill;
    xoff_a = 1'b1;
    xoff_b = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) push(32'h5EED_0100 + 32'(i));
    check(in_ready == 1'b0, "R4 in_ready low when full", {31'd0, in_ready}, 32'd0);
    in_data  = 32'hDEAD_BEEF;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R4 refused write keeps full", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b0;
    xoff_b = 1'b0;
    repeat (6) @(negedge clk);
    check(in_ready == 1'b0, "R5 lane A stop alone holds FIFO", {31'd0, in_ready}, 32'd0);
    xoff_a = 1'b0;
    drain("R4 full FIFO drains without refused word");
  endtask

  task automatic test_toggle;
    fork
      begin
        for (int i = 0; i < 40; i++) push(32'h7000_0000 + 32'(i * 131));
      end
      begin
        for (int k = 0; k < 30; k++) begin
          xoff_a = (k % 3) == 0;
          xoff_b = (k % 5) == 1;
          repeat (1 + (k % 4)) @(negedge clk);
        end
        xoff_a = 1'b0;
        xoff_b = 1'b0;
      end
    join
    drain("R8 toggled stops lose nothing");
    check(want_high == 1'b0, "R7 no dangling half", {31'd0, want_high}, 32'd0);
  endtask

  bit done = 1'b0;

  initial begin
    fork
      begin
        test_reset;
        test_stream;
        test_stop(1'b1, "R5 lane A stop halts");
        test_stop(1'b0, "R6 lane B stop halts");
        test_fill;
        test_toggle;
        done = 1'b1;
      end
      begin
        repeat (100000) @(negedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog actual=timeout expected=finish");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule